// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits between a multiplexed bus front end and a nonvolatile array. It sees every write strobe with its 13-bit address and data byte and decides, in the same cycle, whether that write may be committed to the array. Data writes are refused unless a three-write unlock has just been given. Once the unlock is complete, writes form an open burst. The burst stays open for as long as each write follows the previous one within a byte-load window, counted in clock cycles.

A longer five-write command gives access to an 8-bit lock mask in which each bit guards one 1K block. The write that follows this command loads the mask, and the write after that closes the command. A locked block refuses writes even inside an open burst. A hardware veto input refuses any write made while it is high and sends the sequencer back to idle. The mask is held in an ordinary register with a reset value.

Top module: `wp_seq`

## Requirements
- R1: After reset, `lock_mask` is 0x00, `mask_upd` is 0 and `commit_ok` is 0, and a write made from idle is refused.
- R2: The writes 0xAA to offset 0x555, then 0x55 to offset 0xAAA, then 0xA0 to offset 0x555 open a burst. Every later write in the burst raises `commit_ok` in its own strobe cycle. The command writes themselves never raise `commit_ok`.
- R3: For command writes only address bits [11:0] are compared with the offset, so bit 12 may take either value.
- R4: A write that does not match the next expected command byte and offset returns the sequencer to idle, and `lock_mask` does not change.
- R5: The writes AA@555, 55@AAA, C0@555, AA@555, 55@AAA arm the mask. The next write, to any address, loads its data into `lock_mask` at the following clock edge. `mask_upd` is high for exactly that following cycle.
- R6: Bit n of `lock_mask` (1 = locked) guards addresses with bits [12:10] equal to n. A write in an open burst to a locked block is refused, and the burst stays open.
- R7: Outside idle, each write must come no more than WIN cycles after the previous write. A write exactly WIN cycles later is still accepted. If WIN cycles pass with no write, the sequencer returns to idle.
- R8: A write made while `wr_veto` is high is refused: no commit, no mask load, and the sequencer returns to idle.
- R9: The write after the mask load is consumed as the closing command (A0@555 is expected) and is never committed. Whatever its value, the sequencer then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 13 | Write address; bits [12:10] select the 1K block |
| wr_data | input | 8 | Write data byte |
| wr_veto | input | 1 | Hardware write veto, active high |
| commit_ok | output | 1 | The current write may reach the array |
| lock_mask | output | 8 | Per-block lock mask |
| mask_upd | output | 1 | One-cycle pulse after the mask is loaded |

## Verification
The window expiry and a fresh write can fall in the same cycle. This is provoked by leaving a gap of exactly WIN cycles before a write, and then a gap of WIN+1 cycles. The first write must still commit or advance the sequence, and the second must find the sequencer idle. The veto and a mask-loading or burst write also coincide: the write is driven with the veto high, and the bench expects no commit, no `mask_upd` pulse and an unchanged mask. A cycle-level behavioural model judges every cycle.

// File: rtl/wp_seq.sv
module wp_seq #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int NBLK   = 8,
  parameter int WIN    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_veto,
  output logic              commit_ok,
  output logic [NBLK-1:0]   lock_mask,
  output logic              mask_upd
);
  localparam int BLK_W = $clog2(NBLK);
  localparam int OFS_W = ADDR_W - 1;
  localparam int CNT_W = $clog2(WIN + 1);
  localparam logic [OFS_W-1:0] OFS_A = OFS_W'(12'h555);
  localparam logic [OFS_W-1:0] OFS_B = OFS_W'(12'hAAA);
  localparam logic [DATA_W-1:0] K_AA = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] K_55 = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] K_A0 = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] K_C0 = DATA_W'(8'hC0);

  typedef enum logic [3:0] {
    IDLE, U1, U2, OPEN, M1, M2, M3, LOAD, CLOSE
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;

  wire at_a  = wr_addr[OFS_W-1:0] == OFS_A;
  wire at_b  = wr_addr[OFS_W-1:0] == OFS_B;
  wire hit_aa = at_a && wr_data == K_AA;
  wire hit_55 = at_b && wr_data == K_55;
  wire hit_a0 = at_a && wr_data == K_A0;
  wire hit_c0 = at_a && wr_data == K_C0;
  wire [BLK_W-1:0] blk = wr_addr[ADDR_W-1 -: BLK_W];
  wire good_wr = wr_stb && !wr_veto;

  assign commit_ok = good_wr && st == OPEN && !lock_mask[blk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      lock_mask <= '0;
      mask_upd  <= 1'b0;
    end else begin
      mask_upd <= 1'b0;
      if (wr_stb) begin
        cnt <= '0;
        if (wr_veto) st <= IDLE;
        else begin
          case (st)
            IDLE:  st <= hit_aa ? U1 : IDLE;
            U1:    st <= hit_55 ? U2 : IDLE;
            U2:    st <= hit_a0 ? OPEN : (hit_c0 ? M1 : IDLE);
            OPEN:  st <= OPEN;
            M1:    st <= hit_aa ? M2 : IDLE;
            M2:    st <= hit_55 ? LOAD : IDLE;
            LOAD: begin
              lock_mask <= wr_data[NBLK-1:0];
              mask_upd  <= 1'b1;
              st        <= CLOSE;
            end
            default: st <= IDLE;
          endcase
        end
      end else if (st != IDLE) begin
        if (cnt == CNT_W'(WIN - 1)) begin
          st  <= IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module wp_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int NBLK   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_veto,
  input logic              commit_ok,
  input logic [NBLK-1:0]   lock_mask,
  input logic              mask_upd
);
  localparam int BLK_W = $clog2(NBLK);

  // R2
  commit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> wr_stb);
  // R6
  no_locked_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> !lock_mask[wr_addr[ADDR_W-1 -: BLK_W]]);
  // R8
  veto_blocks_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_veto |-> !commit_ok);
  // R8
  veto_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_veto) |=> !mask_upd);
  // R5
  mask_change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mask != $past(lock_mask)) |-> mask_upd);
  // R5
  upd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_upd |-> $past(wr_stb));
  // R5
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_upd |=> !mask_upd);
endmodule

bind wp_seq wp_seq_chk #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_veto(wr_veto), .commit_ok(commit_ok), .lock_mask(lock_mask),
  .mask_upd(mask_upd)
);

// File: tb/sim_wp_seq.sv
`timescale 1ns/1ps
module sim_wp_seq;
  localparam int WIN = 12;

  logic clk = 0, rst_n = 0, stb = 0, veto = 0;
  logic [12:0] addr = '0;
  logic [7:0] data = '0;
  logic commit_ok, mask_upd;
  logic [7:0] lock_mask;

  wp_seq #(.WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(stb), .wr_addr(addr), .wr_data(data),
    .wr_veto(veto), .commit_ok(commit_ok), .lock_mask(lock_mask),
    .mask_upd(mask_upd)
  );

  always #2.5 clk = ~clk;

  int mst = 0, gap = 0, checks = 0, errors = 0;
  logic [7:0] mmask = 8'h00;
  bit mupd = 0, done = 0;
  string cur_req = "R1";

  function automatic bit is_a(logic [12:0] a); return a[11:0] == 12'h555; endfunction
  function automatic bit is_b(logic [12:0] a); return a[11:0] == 12'hAAA; endfunction

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit s, logic [12:0] a, logic [7:0] d, bit v);
    bit ec;
    @(negedge clk);
    stb = s; addr = a; data = d; veto = v;
    #1;
    ec = s && !v && mst == 3 && !mmask[a[12:10]];
    cmp("commit_ok", {7'b0, commit_ok}, {7'b0, ec});
    cmp("lock_mask", lock_mask, mmask);
    cmp("mask_upd", {7'b0, mask_upd}, {7'b0, mupd});
    @(posedge clk);
    mupd = 0;
    if (s) begin
      gap = 0;
      if (v) mst = 0;
      else case (mst)
        0: mst = (is_a(a) && d == 8'hAA) ? 1 : 0;
        1: mst = (is_b(a) && d == 8'h55) ? 2 : 0;
        2: mst = (is_a(a) && d == 8'hA0) ? 3 : ((is_a(a) && d == 8'hC0) ? 4 : 0);
        3: mst = 3;
        4: mst = (is_a(a) && d == 8'hAA) ? 5 : 0;
        5: mst = (is_b(a) && d == 8'h55) ? 6 : 0;
        6: begin mmask = d; mupd = 1; mst = 7; end
        default: mst = 0;
      endcase
    end else if (mst != 0) begin
      gap++;
      if (gap == WIN) begin mst = 0; gap = 0; end
    end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d); step(1, a, d, 0); endtask
  task automatic nop(int n); for (int i = 0; i < n; i++) step(0, '0, '0, 0); endtask
  task automatic unlock(bit hi);
    wr({hi, 12'h555}, 8'hAA); wr({hi, 12'hAAA}, 8'h55); wr({hi, 12'h555}, 8'hA0);
  endtask
  task automatic arm_mask();
    wr(13'h0555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h0555, 8'hC0);
    wr(13'h1555, 8'hAA); wr(13'h1AAA, 8'h55);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cur_req = "R1"; nop(2); wr(13'h0100, 8'h11); nop(2);
    cur_req = "R2"; unlock(0); wr(13'h0123, 8'h5A); wr(13'h1F00, 8'h01); wr(13'h0800, 8'h77);
    nop(WIN + 1);
    cur_req = "R3"; wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
    wr(13'h0040, 8'h33); nop(WIN + 1);
    cur_req = "R7"; unlock(1); nop(WIN - 1); wr(13'h0200, 8'h44);
    nop(WIN); wr(13'h0200, 8'h45);
    wr(13'h0555, 8'hAA); nop(WIN - 1); wr(13'h0AAA, 8'h55); nop(WIN); wr(13'h0555, 8'hA0);
    wr(13'h0300, 8'h46); nop(WIN + 1);
    cur_req = "R4"; wr(13'h0555, 8'hAA); wr(13'h0AAB, 8'h55); wr(13'h0555, 8'hA0);
    wr(13'h0010, 8'h01); wr(13'h0555, 8'hAA); wr(13'h0AAA, 8'h56); wr(13'h0555, 8'hA0);
    wr(13'h0010, 8'h02); nop(WIN + 1);
    cur_req = "R8"; unlock(0); wr(13'h0020, 8'h01); step(1, 13'h0021, 8'h02, 1);
    wr(13'h0022, 8'h03);
    wr(13'h0555, 8'hAA); wr(13'h0AAA, 8'h55); step(1, 13'h0555, 8'hA0, 1);
    wr(13'h0023, 8'h04); nop(WIN + 1);
    cur_req = "R5"; arm_mask(); wr(13'h1234, 8'h05); nop(1);
    cur_req = "R9"; wr(13'h0555, 8'hA0); wr(13'h0400, 8'h09); nop(WIN + 1);
    cur_req = "R6"; unlock(0); wr(13'h0000, 8'h01); wr(13'h0400, 8'h02);
    wr(13'h0BFF, 8'h03); wr(13'h1C00, 8'h04); wr(13'h0FFF, 8'h05); nop(WIN + 1);
    cur_req = "R8"; arm_mask(); step(1, 13'h0000, 8'hF0, 1); nop(2);
    cur_req = "R9"; arm_mask(); wr(13'h0000, 8'hFF); wr(13'h0400, 8'h11); wr(13'h0400, 8'h12);
    cur_req = "R6"; unlock(1); wr(13'h0800, 8'h01); wr(13'h1FFF, 8'h02); nop(WIN + 1);
    cur_req = "R5"; arm_mask(); wr(13'h0ABC, 8'h00); wr(13'h0555, 8'hA0); nop(2);
    unlock(0); wr(13'h0000, 8'h21); nop(WIN + 2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule